// File: doc/BRIEF.md
# Shared Product-Term Logic Array

This block is the combinational heart of one logic block in a programmable-array style device. A bank of routed input signals is presented to a pool of configurable AND terms. Each input can take part in any term in its true form, its inverted form, or both. The pool is split by position. The lowest eight terms serve as local control terms (clocks, resets, presets, output enables). The next eight are foldback NAND terms whose inverted results come back as extra literals. One group gives each macrocell a dedicated single term, and a final group supplies per-macrocell product-term clocks.

Every macrocell owns an OR gate that may select any subset of the whole pool, so one term can be shared by several macrocells. A per-macrocell variable-function mux then applies any programmed two-input function to that macrocell's single term and its OR result. Four of the control terms can also be switched to form a sum of their literals instead of a product.

All programming lives in one flat configuration vector. The vector is loaded through a word-wide shift port, where a word width of one gives a plain serial load. The outputs follow the inputs with no clock latency. The clock only moves configuration.

Top module: `pla_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load, the configuration is all zero and every output is 0. Release takes effect on the second rising clock edge after `rst_n` rises.
- R2: On each rising edge with `cfg_ld` high, the configuration shifts down by LOAD_W bits and `cfg_word` enters at the top. After CFG_W/LOAD_W loads, the first word occupies bits [LOAD_W-1:0]. With `cfg_ld` low the configuration holds, whatever `cfg_word` does.
- R3: Term t is programmed by the LIT_W = 2*N_IN+8 bits starting at bit t*LIT_W. Field bit i enables the true form of `in_sig[i]`. Field bit N_IN+i enables its inverted form. Field bit 2*N_IN+f enables foldback literal f. A product term is the AND of its enabled literals.
- R4: A product term with no enabled literal gives 0, a sum-mode term with none gives 0, and an OR with no selected term gives 0.
- R5: Terms 0..7 drive `lct[7:0]`, term 8+8+m drives `pt_single[m]`, and term 16+N_MC+m drives `pt_clk[m]`.
- R6: Terms 8..15 are foldback terms. Foldback literal f equals the inverse of term 8+f. The foldback literal bits of a foldback term's own field are ignored, so a foldback term sees only the block inputs.
- R7: Bit t of the N_PT-bit group starting at N_PT*LIT_W + m*N_PT selects term t into `or_term[m]`, which is the OR of all selected terms. Any term may be selected by any number of macrocells.
- R8: The 4-bit table at N_PT*LIT_W + N_MC*N_PT + 4*m sets `vfm_out[m]` to table bit {`pt_single[m]`, `or_term[m]`}, with the single term as the upper index bit.
- R9: Bit k (k = 0..3) of the 4-bit group after all tables puts term 4+k in sum mode when 1: it becomes the OR of its enabled literals. Terms 0..3 are always products.
- R10: All outputs respond to `in_sig` within the same clock cycle, with no register between `in_sig` and any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration loading |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_ld | input | 1 | Shift one configuration word in this cycle |
| cfg_word | input | LOAD_W | Configuration word entering at the top |
| in_sig | input | N_IN | Routed block inputs |
| lct | output | 8 | Local control terms 0..7 |
| pt_single | output | N_MC | Dedicated single term per macrocell |
| pt_clk | output | N_MC | Product-term clock per macrocell |
| or_term | output | N_MC | Shared OR result per macrocell |
| vfm_out | output | N_MC | Variable-function mux result per macrocell |

## Verification
The bench builds the block with N_IN=6, N_MC=4 and LOAD_W=4. This gives 24 terms and a 596-bit vector loaded in 149 words. Six inputs allow an exhaustive sweep of all 64 input patterns in the foldback and sum-mode tests, so every literal combination of the directed terms is seen. The small vector also keeps each load short enough to run several random configurations, a partial one-word shift and a hold period with a busy `cfg_word`.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int N_LCT   = 8;  // local control terms at the bottom of the pool
  localparam int N_FB    = 8;  // foldback NAND terms above them
  localparam int N_SUMSW = 4;  // control terms 4..7 may switch to sum form
  localparam int SUM_LO  = 4;
  localparam int VFM_W   = 4;  // truth-table bits per macrocell mux

  typedef enum logic {
    TERM_PRODUCT = 1'b0,
    TERM_SUM     = 1'b1
  } term_mode_e;
endpackage

// File: rtl/pla_cfg_reg.sv
module pla_cfg_reg #(
  parameter int CFG_W  = 64,
  parameter int LOAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ld,
  input  logic [LOAD_W-1:0] cfg_word,
  output logic [CFG_W-1:0]  cfg
);
  localparam int N_WORDS = (CFG_W + LOAD_W - 1) / LOAD_W;
  localparam int SR_W    = N_WORDS * LOAD_W;

  logic [SR_W-1:0] sr_q, sr_d;

  generate
    if (SR_W == LOAD_W) begin : g_single
      always_comb sr_d = cfg_word;
    end else begin : g_shift
      always_comb sr_d = {cfg_word, sr_q[SR_W-1:LOAD_W]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (cfg_ld) begin
      sr_q <= sr_d;
    end
  end

  assign cfg = sr_q[CFG_W-1:0];
endmodule

// File: rtl/pla_term.sv
module pla_term #(
  parameter int N_IN  = 36,
  parameter int N_FB  = 8,
  parameter bit IS_FB = 1'b0
) (
  input  logic [2*N_IN+N_FB-1:0] lit_en,
  input  logic [N_IN-1:0]        in_sig,
  input  logic [N_FB-1:0]        fb_lit,
  input  logic                   sum_mode,
  output logic                   term
);
  localparam int LIT_W = 2 * N_IN + N_FB;

  logic [LIT_W-1:0] lit_v, en_v;

  always_comb begin
    lit_v = {fb_lit, ~in_sig, in_sig};
    en_v  = lit_en;
    // a foldback term must not see foldback literals: no loop through the pool
    if (IS_FB) en_v[LIT_W-1 -: N_FB] = '0;
    if (sum_mode) term = |(en_v & lit_v);
    else          term = (|en_v) & (&(lit_v | ~en_v));
  end
endmodule

// File: rtl/pla_mc_out.sv
module pla_mc_out #(
  parameter int N_PT = 48
) (
  input  logic [N_PT-1:0] sel,
  input  logic [N_PT-1:0] pt_vec,
  input  logic            single,
  input  logic [3:0]      tbl,
  output logic            or_t,
  output logic            vfm
);
  always_comb begin
    or_t = |(sel & pt_vec);
    vfm  = tbl[{single, or_t}];
  end
endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_MC   = 16,
  parameter int LOAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ld,
  input  logic [LOAD_W-1:0] cfg_word,
  input  logic [N_IN-1:0]   in_sig,
  output logic [N_LCT-1:0]  lct,
  output logic [N_MC-1:0]   pt_single,
  output logic [N_MC-1:0]   pt_clk,
  output logic [N_MC-1:0]   or_term,
  output logic [N_MC-1:0]   vfm_out
);
  localparam int N_PT      = N_LCT + N_FB + 2 * N_MC;
  localparam int LIT_W     = 2 * N_IN + N_FB;
  localparam int SG_LO     = N_LCT + N_FB;
  localparam int CK_LO     = SG_LO + N_MC;
  localparam int OR_BASE   = N_PT * LIT_W;
  localparam int VFM_BASE  = OR_BASE + N_MC * N_PT;
  localparam int MODE_BASE = VFM_BASE + VFM_W * N_MC;
  localparam int CFG_W     = MODE_BASE + N_SUMSW;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe_q[1];

  logic [CFG_W-1:0] cfg_q;

  pla_cfg_reg #(.CFG_W(CFG_W), .LOAD_W(LOAD_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cfg_ld   (cfg_ld),
    .cfg_word (cfg_word),
    .cfg      (cfg_q)
  );

  logic [N_PT-1:0] pt_vec;
  logic [N_FB-1:0] fb_and;
  logic [N_FB-1:0] fb_nand;

  assign fb_nand = ~fb_and;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    if (t >= N_LCT && t < N_LCT + N_FB) begin : g_fb
      pla_term #(.N_IN(N_IN), .N_FB(N_FB), .IS_FB(1'b1)) u_term (
        .lit_en   (cfg_q[t*LIT_W +: LIT_W]),
        .in_sig   (in_sig),
        .fb_lit   ({N_FB{1'b0}}),
        .sum_mode (1'b0),
        .term     (fb_and[t-N_LCT])
      );
      assign pt_vec[t] = fb_and[t-N_LCT];
    end else begin : g_std
      logic mode_b;
      if (t >= SUM_LO && t < SUM_LO + N_SUMSW) begin : g_sw
        assign mode_b = (cfg_q[MODE_BASE + t - SUM_LO] == TERM_SUM);
      end else begin : g_fix
        assign mode_b = 1'b0;
      end
      pla_term #(.N_IN(N_IN), .N_FB(N_FB), .IS_FB(1'b0)) u_term (
        .lit_en   (cfg_q[t*LIT_W +: LIT_W]),
        .in_sig   (in_sig),
        .fb_lit   (fb_nand),
        .sum_mode (mode_b),
        .term     (pt_vec[t])
      );
    end
  end

  assign lct = pt_vec[N_LCT-1:0];

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    assign pt_single[m] = pt_vec[SG_LO + m];
    assign pt_clk[m]    = pt_vec[CK_LO + m];

    pla_mc_out #(.N_PT(N_PT)) u_mc (
      .sel    (cfg_q[OR_BASE + m*N_PT +: N_PT]),
      .pt_vec (pt_vec),
      .single (pt_vec[SG_LO + m]),
      .tbl    (cfg_q[VFM_BASE + VFM_W*m +: VFM_W]),
      .or_t   (or_term[m]),
      .vfm    (vfm_out[m])
    );
  end
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN = 36,
  parameter int N_MC = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_ld,
  input logic [(2*N_IN+8)*(16+2*N_MC)+N_MC*(16+2*N_MC)+4*N_MC+4-1:0] cfg,
  input logic [7:0]           lct,
  input logic [N_MC-1:0]      pt_single,
  input logic [N_MC-1:0]      pt_clk,
  input logic [N_MC-1:0]      or_term,
  input logic [N_MC-1:0]      vfm_out
);
  localparam int N_PT      = 16 + 2 * N_MC;
  localparam int LIT_W     = 2 * N_IN + 8;
  localparam int OR_BASE   = N_PT * LIT_W;
  localparam int VFM_BASE  = OR_BASE + N_MC * N_PT;
  localparam int MODE_BASE = VFM_BASE + 4 * N_MC;

  logic seen_ld_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ld_q <= 1'b0;
    end else if (cfg_ld) begin
      seen_ld_q <= 1'b1;
    end
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_ld_q |-> (lct == '0 && pt_single == '0 && pt_clk == '0 &&
                    or_term == '0 && vfm_out == '0));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ld |=> $stable(cfg));

  for (genvar k = 0; k < 8; k++) begin : g_lct
    assert_lct_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[k*LIT_W +: LIT_W] == '0) |-> !lct[k]);
    if (k < 4) begin : g_prod
      assert_contra_prod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[k*LIT_W] && cfg[k*LIT_W + N_IN]) |-> !lct[k]);
    end else begin : g_sum
      assert_taut_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[MODE_BASE + k - 4] && cfg[k*LIT_W] && cfg[k*LIT_W + N_IN]) |-> lct[k]);
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    assert_or_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[OR_BASE + m*N_PT +: N_PT] == '0) |-> !or_term[m]);
    assert_vfm_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vfm_out[m] == cfg[VFM_BASE + 4*m + 2*pt_single[m] + or_term[m]]);
  end
endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_MC(N_MC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_ld    (cfg_ld),
  .cfg       (cfg_q),
  .lct       (lct),
  .pt_single (pt_single),
  .pt_clk    (pt_clk),
  .or_term   (or_term),
  .vfm_out   (vfm_out)
);

// File: tb/test_pla_core.sv
module test_pla_core;
  localparam int N_IN      = 6;
  localparam int N_MC      = 4;
  localparam int LOAD_W    = 4;
  localparam int N_PT      = 16 + 2 * N_MC;
  localparam int LIT_W     = 2 * N_IN + 8;
  localparam int OR_BASE   = N_PT * LIT_W;
  localparam int VFM_BASE  = OR_BASE + N_MC * N_PT;
  localparam int MODE_BASE = VFM_BASE + 4 * N_MC;
  localparam int CFG_W     = MODE_BASE + 4;
  localparam int N_WORDS   = CFG_W / LOAD_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_ld;
  logic [LOAD_W-1:0] cfg_word;
  logic [N_IN-1:0]   in_sig;
  logic [7:0]        lct;
  logic [N_MC-1:0]   pt_single, pt_clk, or_term, vfm_out;

  always #4 clk = ~clk;

  pla_core #(.N_IN(N_IN), .N_MC(N_MC), .LOAD_W(LOAD_W)) i_pla_core (
    .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_word(cfg_word), .in_sig(in_sig),
    .lct(lct), .pt_single(pt_single), .pt_clk(pt_clk), .or_term(or_term), .vfm_out(vfm_out)
  );

  typedef struct {
    logic [7:0]      lct;
    logic [N_MC-1:0] sg, ck, orr, vf;
    string           tag;
  } exp_t;

  exp_t             exp_q[$];
  logic [CFG_W-1:0] mcfg;
  int               n_total = 0;
  int               n_bad   = 0;
  bit               done    = 1'b0;

  function automatic logic term_val(input logic [CFG_W-1:0] c, input int t,
                                    input logic [N_IN-1:0] x, input logic [7:0] nb,
                                    input bit is_fb, input bit sum);
    logic any = 1'b0, all = 1'b1, orv = 1'b0, lit;
    for (int j = 0; j < LIT_W; j++) begin
      if (c[t*LIT_W + j] && !(is_fb && j >= 2*N_IN)) begin
        if (j < N_IN)          lit = x[j];
        else if (j < 2*N_IN)   lit = ~x[j-N_IN];
        else                   lit = nb[j-2*N_IN];
        any = 1'b1;
        all = all & lit;
        orv = orv | lit;
      end
    end
    return sum ? orv : (any & all);
  endfunction

  function automatic exp_t model(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x,
                                 input string tag);
    exp_t e;
    logic [N_PT-1:0] pt;
    logic [7:0] nb;
    for (int f = 0; f < 8; f++) begin
      pt[8+f] = term_val(c, 8+f, x, 8'h00, 1'b1, 1'b0);
      nb[f]   = ~pt[8+f];
    end
    for (int t = 0; t < N_PT; t++)
      if (t < 8 || t >= 16)
        pt[t] = term_val(c, t, x, nb, 1'b0, (t >= 4 && t < 8) ? c[MODE_BASE+t-4] : 1'b0);
    e.lct = pt[7:0];
    for (int m = 0; m < N_MC; m++) begin
      e.sg[m]  = pt[16+m];
      e.ck[m]  = pt[16+N_MC+m];
      e.orr[m] = |(pt & c[OR_BASE + m*N_PT +: N_PT]);
      e.vf[m]  = c[VFM_BASE + 4*m + 2*e.sg[m] + e.orr[m]];
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [N_IN-1:0] x, input string tag);
    @(posedge clk);
    #1 in_sig = x;
    exp_q.push_back(model(mcfg, x, tag));
  endtask

  task automatic load_cfg(input logic [CFG_W-1:0] c);
    for (int k = 0; k < N_WORDS; k++) begin
      @(posedge clk);
      #1 cfg_ld = 1'b1;
      cfg_word  = c[k*LOAD_W +: LOAD_W];
    end
    @(posedge clk);
    #1 cfg_ld = 1'b0;
    mcfg = c;
  endtask

  task automatic cmp(input string tag, input string what, input logic [7:0] got,
                     input logic [7:0] want);
    n_total++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, want);
    end
  endtask

  // monitor: sampled mid-cycle, same cycle as the drive (R10)
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "lct",       lct,              e.lct);
        cmp(e.tag, "pt_single", 8'(pt_single),    8'(e.sg));
        cmp(e.tag, "pt_clk",    8'(pt_clk),       8'(e.ck));
        cmp(e.tag, "or_term",   8'(or_term),      8'(e.orr));
        cmp(e.tag, "vfm_out",   8'(vfm_out),      8'(e.vf));
      end
    end
  end

  function automatic logic [CFG_W-1:0] rand_cfg();
    logic [CFG_W-1:0] c = '0;
    for (int b = 0; b < OR_BASE; b++)           c[b] = ($urandom_range(5) == 0);
    for (int b = OR_BASE; b < VFM_BASE; b++)    c[b] = ($urandom_range(3) == 0);
    for (int b = VFM_BASE; b < CFG_W; b++)      c[b] = $urandom_range(1);
    return c;
  endfunction

  initial begin
    logic [CFG_W-1:0] c;
    rst_n = 1'b0; cfg_ld = 1'b0; cfg_word = '0; in_sig = '0; mcfg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: cleared after reset
    for (int i = 0; i < 8; i++) drive(N_IN'($urandom), "R1 reset state");

    // R3 R5 R6 R7 R8 R9 R10: random configurations
    for (int r = 0; r < 3; r++) begin
      load_cfg(rand_cfg());
      for (int i = 0; i < 30; i++) drive(N_IN'($urandom), "R3 R5 R7 R10 random");
    end

    // R2: hold while cfg_word wiggles with cfg_ld low
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      #1 cfg_word = LOAD_W'($urandom);
    end
    for (int i = 0; i < 10; i++) drive(N_IN'($urandom), "R2 hold");

    // R2: one extra word shifts the whole vector down
    @(posedge clk);
    #1 cfg_ld = 1'b1; cfg_word = 4'hB;
    @(posedge clk);
    #1 cfg_ld = 1'b0;
    mcfg = {4'hB, mcfg[CFG_W-1:LOAD_W]};
    for (int i = 0; i < 10; i++) drive(N_IN'($urandom), "R2 shift");

    // R6: foldback literals
    c = '0;
    c[8*LIT_W + 0]             = 1'b1;  // term 8 = in0
    c[0*LIT_W + 2*N_IN + 0]    = 1'b1;  // lct0 = ~term8
    c[9*LIT_W + 1]             = 1'b1;  // term 9 = in1
    c[9*LIT_W + 2*N_IN + 1]    = 1'b1;  // own foldback bit: ignored
    c[1*LIT_W + 2*N_IN + 1]    = 1'b1;  // lct1 = ~term9
    c[2*LIT_W + 2*N_IN + 0]    = 1'b1;  // lct2 = ~in0 & in2
    c[2*LIT_W + 2]             = 1'b1;
    load_cfg(c);
    for (int i = 0; i < 64; i++) drive(N_IN'(i), "R6 foldback");

    // R4 R7 R8: empty terms, shared OR, mux tables
    c = '0;
    c[16*LIT_W + 0]            = 1'b1;  // single0 = in0
    c[17*LIT_W + N_IN + 1]     = 1'b1;  // single1 = ~in1
    c[OR_BASE + 1*N_PT + 16]   = 1'b1;
    c[OR_BASE + 1*N_PT + 17]   = 1'b1;
    c[OR_BASE + 2*N_PT + 16]   = 1'b1;
    c[OR_BASE + 3*N_PT + 16]   = 1'b1;
    c[OR_BASE + 3*N_PT + 22]   = 1'b1;  // empty term 22 in an OR
    c[VFM_BASE + 0 +: 4]       = 4'b0001;
    c[VFM_BASE + 4 +: 4]       = 4'b0110;
    c[VFM_BASE + 8 +: 4]       = 4'b1000;
    c[VFM_BASE + 12 +: 4]      = 4'b1110;
    load_cfg(c);
    for (int i = 0; i < 64; i++) drive(N_IN'(i), "R4 R7 R8 directed");

    // R9: sum mode against product mode
    c = '0;
    c[4*LIT_W + 0] = 1'b1; c[4*LIT_W + 1] = 1'b1; c[MODE_BASE + 0] = 1'b1;
    c[5*LIT_W + 0] = 1'b1; c[5*LIT_W + 1] = 1'b1;
    c[MODE_BASE + 2] = 1'b1;                  // term 6 empty sum
    c[7*LIT_W + N_IN + 3] = 1'b1; c[7*LIT_W + 2*N_IN + 0] = 1'b1; c[MODE_BASE + 3] = 1'b1;
    c[8*LIT_W + 3] = 1'b1;
    load_cfg(c);
    for (int i = 0; i < 64; i++) drive(N_IN'(i), "R9 sum mode");

    // R1: reset again clears a loaded configuration
    load_cfg(rand_cfg());
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    mcfg = '0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 8; i++) drive(N_IN'($urandom), "R1 reset again");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_total++;
      $display("FAIL watchdog R10 got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule